// File: doc/BRIEF.md
# Flash Read Prefetch Controller

This block sits in front of a flash array that returns one 64-bit line per read and needs a programmable number of extra cycles to do so. Two 32-bit read ports share the array. The instruction port is backed by a two-entry line buffer, so a sequential stream of fetches usually finds its word already buffered. When the upper word of a line is consumed and the array is idle, the block starts reading the next line in the background. The data port, which also carries DMA traffic, goes straight to the array and never touches the buffer. It wins every conflict, except that after each DMA read it gives up the next array slot so a waiting instruction access can proceed.

Both ports use the same handshake. The requester holds `xReq` and its address until a one-cycle `xDone` pulse, which carries the read word. In that pulse cycle it may already present its next request or drop `xReq`. Addresses are 32-bit word addresses. Bit 0 picks the half of a 64-bit line, and the upper bits form the line address sent to the array. The array drives `arrData` from `arrAddr` and is sampled at the end of the last cycle of each read.

Top module: `flash_read_accel`

## Requirements
- R1: While reset is applied and just after it is released, `iDone`, `dDone` and `arrEn` are low and the line buffer is empty, so the first fetch is a miss.
- R2: Every array read keeps `arrEn` high and `arrAddr` steady for waitCfg+1 cycles. The code 3 is treated as 2. The value is sampled when the read starts, so changing `waitCfg` during a read does not alter that read.
- R3: A fetch that hits the buffer raises `iDone` in the cycle after its request is first sampled. Address bit 0 = 0 returns line bits 31:0, and bit 0 = 1 returns bits 63:32.
- R4: On an instruction miss with the array idle, the line read starts at once. `iDone` comes ws+2 cycles after the request is sampled. The line is then written into the least recently filled of the two entries.
- R5: A data-port read on an idle array returns its word ws+2 cycles after the request and allocates no buffer entry.
- R6: When a data request and an instruction miss contend for an idle array, the data read goes first and the instruction miss follows after it.
- R7: After a read flagged with `dDma` completes, the next free array slot is closed to the data port. A back-to-back DMA read then takes ws+3 cycles, and a waiting instruction miss is served before it.
- R8: A hit on an upper word with the array idle starts a read of the following line when that line is not buffered. A fetch of that line that arrives while the read is in flight completes ws+1 cycles after it is sampled.
- R9: An instruction miss on another line aborts an in-flight prefetch that is not in its last cycle. The demand read then starts in the same cycle, and the aborted line is not stored.
- R10: Instruction hits are served with one-cycle latency while the array is busy with a data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| waitCfg | input | 2 | Extra cycles per array read (0..2, 3 acts as 2) |
| iReq | input | 1 | Instruction fetch request, held until iDone |
| iAddr | input | AW | Instruction word address |
| iDone | output | 1 | One-cycle pulse: iRdata valid |
| iRdata | output | 32 | Fetched instruction word |
| dReq | input | 1 | Data/DMA read request, held until dDone |
| dDma | input | 1 | Marks the data request as a DMA transfer |
| dAddr | input | AW | Data word address |
| dDone | output | 1 | One-cycle pulse: dRdata valid |
| dRdata | output | 32 | Read data word |
| arrEn | output | 1 | Array read in progress |
| arrAddr | output | AW-1 | Line address presented to the array |
| arrData | input | 64 | Line returned by the array |

## Verification
Every wait-state code, including the clamped code 3, is swept with a sequential fetch stream across several lines. The stream separates cold misses, lower- and upper-word hits and fetches that wait on a background prefetch. The stream is followed by re-fetches that tell a least-recently-filled victim choice apart from a least-recently-used one. Data and instruction requests are then launched in the same cycle, with and without the DMA flag and with the data port re-requesting at once. This shows both the priority order and the one-slot yield. A jump made right after a prefetch starts shows whether the prefetch was dropped or completed, and a mid-read wait-state change shows the value is latched when the read starts.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;

  // number of buffered lines (must be at least 2)
  parameter int unsigned PF_ENTRIES = 2;
  localparam int unsigned IDX_W = $clog2(PF_ENTRIES);

  typedef enum logic [1:0] {
    RD_DATA,
    RD_DEMAND,
    RD_PREF
  } rdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             fillEn;     // write arrData into a buffer entry
    logic [IDX_W-1:0] fillIdx;
    logic             iLoad;      // load instruction read register
    logic             iFromFill;  // take the word from arrData (forward)
    logic [IDX_W-1:0] iIdx;       // buffer entry that hit
    logic             iHi;        // upper word of the line
    logic             dLoad;      // load data read register
    logic             dHi;
  } dpStrobe_t;

endpackage

// File: rtl/flash_pf_ctrl.sv
module flash_pf_ctrl
  import flash_pf_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    waitCfg,
  input  logic          iReq,
  input  logic [AW-1:0] iAddr,
  input  logic          dReq,
  input  logic          dDma,
  input  logic [AW-1:0] dAddr,
  output logic          iDone,
  output logic          dDone,
  output logic          arrEn,
  output logic [AW-2:0] arrAddr,
  output dpStrobe_t     strb
);

  localparam int unsigned LAW = AW - 1;
  localparam int unsigned ENT = PF_ENTRIES;

  // array read state
  logic           busy;
  rdKind_t        kind;
  logic [1:0]     cnt;
  logic [LAW-1:0] lineAddr;
  logic           dHiQ;
  logic           dmaQ;
  logic           dmaGap;

  // buffer bookkeeping
  logic [ENT-1:0]   validQ;
  logic [LAW-1:0]   tagQ [ENT];
  logic [IDX_W-1:0] fillPtr;

  logic iDoneQ;
  logic dDoneQ;

  // lookup
  logic [LAW-1:0]   iLine;
  logic [LAW-1:0]   nextLine;
  logic             bufHit;
  logic             nextIn;
  logic [IDX_W-1:0] hitIdx;

  assign iLine    = iAddr[AW-1:1];
  assign nextLine = iLine + 1'b1;

  always_comb begin
    bufHit = 1'b0;
    nextIn = 1'b0;
    hitIdx = '0;
    for (int e = 0; e < ENT; e++) begin
      if (validQ[e] && tagQ[e] == iLine) begin
        bufHit = 1'b1;
        hitIdx = IDX_W'(e);
      end
      if (validQ[e] && tagQ[e] == nextLine) nextIn = 1'b1;
    end
  end

  // decisions
  logic       complete;
  logic       fwd;
  logic       iHit;
  logic       iMiss;
  logic       abortNow;
  logic       free;
  logic       launchData;
  logic       launchDemand;
  logic       launchPref;
  logic [1:0] wsEff;

  assign complete     = busy && (cnt == 2'd0);
  assign fwd          = complete && (kind != RD_DATA) && (lineAddr == iLine);
  assign iHit         = iReq && (bufHit || fwd);
  assign iMiss        = iReq && !bufHit && !fwd;
  assign abortNow     = busy && (kind == RD_PREF) && !complete && iMiss && (lineAddr != iLine);
  assign free         = !busy || abortNow;
  assign launchData   = free && dReq && !dmaGap;
  assign launchDemand = free && !launchData && iMiss;
  assign launchPref   = free && !launchData && !iMiss && iHit && iAddr[0] && !nextIn;
  assign wsEff        = (waitCfg == 2'd3) ? 2'd2 : waitCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      kind     <= RD_DATA;
      cnt      <= 2'd0;
      lineAddr <= '0;
      dHiQ     <= 1'b0;
      dmaQ     <= 1'b0;
      dmaGap   <= 1'b0;
      validQ   <= '0;
      fillPtr  <= '0;
      iDoneQ   <= 1'b0;
      dDoneQ   <= 1'b0;
      for (int e = 0; e < ENT; e++) tagQ[e] <= '0;
    end else begin
      iDoneQ <= iHit;
      dDoneQ <= complete && (kind == RD_DATA);

      if (free) dmaGap <= 1'b0;
      else if (complete && kind == RD_DATA) dmaGap <= dmaQ;

      if (launchData || launchDemand || launchPref) begin
        busy <= 1'b1;
        cnt  <= wsEff;
        if (launchData) begin
          kind     <= RD_DATA;
          lineAddr <= dAddr[AW-1:1];
          dHiQ     <= dAddr[0];
          dmaQ     <= dDma;
        end else if (launchDemand) begin
          kind     <= RD_DEMAND;
          lineAddr <= iLine;
        end else begin
          kind     <= RD_PREF;
          lineAddr <= nextLine;
        end
      end else if (complete) begin
        busy <= 1'b0;
        if (kind != RD_DATA) begin
          validQ[fillPtr] <= 1'b1;
          tagQ[fillPtr]   <= lineAddr;
          if (fillPtr == IDX_W'(ENT - 1)) fillPtr <= '0;
          else fillPtr <= fillPtr + 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign iDone   = iDoneQ;
  assign dDone   = dDoneQ;
  assign arrEn   = busy;
  assign arrAddr = lineAddr;

  always_comb begin
    strb           = '0;
    strb.fillEn    = complete && (kind != RD_DATA);
    strb.fillIdx   = fillPtr;
    strb.iLoad     = iHit;
    strb.iFromFill = fwd;
    strb.iIdx      = hitIdx;
    strb.iHi       = iAddr[0];
    strb.dLoad     = complete && (kind == RD_DATA);
    strb.dHi       = dHiQ;
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != 2'd0 && !abortNow) |=>
      (busy && $stable(lineAddr) && cnt == $past(cnt) - 2'd1));

  // R6
  one_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({launchData, launchDemand, launchPref}));

  // R7
  dma_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == 2'd0 && kind == RD_DATA && dmaQ) |-> ##2 !(busy && kind == RD_DATA));

  // R5
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && kind == RD_DATA) |=> $stable(validQ));

endmodule

// File: rtl/flash_pf_dp.sv
module flash_pf_dp
  import flash_pf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [63:0] arrData,
  output logic [31:0] iRdata,
  output logic [31:0] dRdata
);

  logic [63:0] lineQ [PF_ENTRIES];

  for (genvar g = 0; g < PF_ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineQ[g] <= '0;
      else if (strb.fillEn && strb.fillIdx == IDX_W'(g)) lineQ[g] <= arrData;
    end

    // R4
    fill_store_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.fillEn && strb.fillIdx == IDX_W'(g)) |=> (lineQ[g] == $past(arrData)));
  end

  logic [63:0] iSrc;
  assign iSrc = strb.iFromFill ? arrData : lineQ[strb.iIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iRdata <= '0;
      dRdata <= '0;
    end else begin
      if (strb.iLoad) iRdata <= strb.iHi ? iSrc[63:32] : iSrc[31:0];
      if (strb.dLoad) dRdata <= strb.dHi ? arrData[63:32] : arrData[31:0];
    end
  end

endmodule

// File: rtl/flash_read_accel.sv
module flash_read_accel
  import flash_pf_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    waitCfg,
  input  logic          iReq,
  input  logic [AW-1:0] iAddr,
  output logic          iDone,
  output logic [31:0]   iRdata,
  input  logic          dReq,
  input  logic          dDma,
  input  logic [AW-1:0] dAddr,
  output logic          dDone,
  output logic [31:0]   dRdata,
  output logic          arrEn,
  output logic [AW-2:0] arrAddr,
  input  logic [63:0]   arrData
);

  dpStrobe_t strb;

  flash_pf_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .waitCfg (waitCfg),
    .iReq    (iReq),
    .iAddr   (iAddr),
    .dReq    (dReq),
    .dDma    (dDma),
    .dAddr   (dAddr),
    .iDone   (iDone),
    .dDone   (dDone),
    .arrEn   (arrEn),
    .arrAddr (arrAddr),
    .strb    (strb)
  );

  flash_pf_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .arrData (arrData),
    .iRdata  (iRdata),
    .dRdata  (dRdata)
  );

endmodule

// File: tb/flash_read_accel_tb.sv
module flash_read_accel_tb;

  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    waitCfg = 2'd0;
  logic          iReq = 1'b0;
  logic [AW-1:0] iAddr = '0;
  logic          iDone;
  logic [31:0]   iRdata;
  logic          dReq = 1'b0;
  logic          dDma = 1'b0;
  logic [AW-1:0] dAddr = '0;
  logic          dDone;
  logic [31:0]   dRdata;
  logic          arrEn;
  logic [AW-2:0] arrAddr;
  logic [63:0]   arrData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [31:0] wordOf(input logic [AW-1:0] a);
    return 32'hC3A5_0000 ^ (32'(a) * 32'h9E37_79B1);
  endfunction

  function automatic logic [AW-1:0] wa(input int line, input int hi);
    return AW'(line * 2 + hi);
  endfunction

  // array model: line content computed from its address
  assign arrData = {wordOf({arrAddr, 1'b1}), wordOf({arrAddr, 1'b0})};

  flash_read_accel #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .waitCfg(waitCfg),
    .iReq(iReq), .iAddr(iAddr), .iDone(iDone), .iRdata(iRdata),
    .dReq(dReq), .dDma(dDma), .dAddr(dAddr), .dDone(dDone), .dRdata(dRdata),
    .arrEn(arrEn), .arrAddr(arrAddr), .arrData(arrData)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doFetch(input logic [AW-1:0] a, input int expN, input string tag);
    int n;
    n = 0;
    iReq = 1'b1;
    iAddr = a;
    do begin
      @(negedge clk);
      n++;
    end while (!iDone && n < 100);
    check({tag, " latency"}, n, expN);
    check({tag, " data"}, iRdata, wordOf(a));
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic dma, input int expN, input string tag);
    int n;
    n = 0;
    dReq = 1'b1;
    dDma = dma;
    dAddr = a;
    do begin
      @(negedge clk);
      n++;
    end while (!dDone && n < 100);
    check({tag, " latency"}, n, expN);
    check({tag, " data"}, dRdata, wordOf(a));
  endtask

  task automatic idle(input int c);
    iReq = 1'b0;
    dReq = 1'b0;
    dDma = 1'b0;
    repeat (c) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    iReq = 1'b0;
    dReq = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset iDone", iDone, 0);
    check("R1 reset dDone", dDone, 0);
    check("R1 reset arrEn", arrEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset arrEn", arrEn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int ws = 0; ws < 4; ws++) begin
      int w;
      int b;
      w = (ws == 3) ? 2 : ws;
      b = ws * 60 + 8;
      waitCfg = 2'(ws);
      doReset();

      // sequential stream: cold miss, hits, prefetch waits (R1 R3 R4 R8 R2)
      doFetch(wa(b, 0), w + 2, "R1 R4 cold miss");
      doFetch(wa(b, 1), 1, "R3 upper word hit");
      for (int k = 1; k < 4; k++) begin
        doFetch(wa(b + k, 0), w + 1, "R8 prefetched line");
        doFetch(wa(b + k, 1), 1, "R3 upper word hit");
      end
      idle(6);
      doFetch(wa(b + 4, 0), 1, "R8 background prefetch hit");
      doFetch(wa(b + 3, 0), 1, "R3 lower word hit");
      doFetch(wa(b + 2, 0), w + 2, "R4 evicted line misses");
      doFetch(wa(b + 4, 0), 1, "R4 newer fill kept");
      doFetch(wa(b + 3, 0), w + 2, "R4 oldest fill evicted");
      idle(2);

      // data port bypass without allocation (R5)
      doRead(wa(b + 10, 1), 1'b0, w + 2, "R5 data read");
      idle(1);
      doFetch(wa(b + 10, 1), w + 2, "R5 no allocation");
      idle(2);

      // contention (R6)
      fork
        begin doRead(wa(b + 12, 0), 1'b0, w + 2, "R6 data first"); dReq = 1'b0; end
        begin doFetch(wa(b + 11, 0), 2 * w + 4, "R6 instruction second"); iReq = 1'b0; end
      join
      idle(2);

      // DMA free slot (R7)
      fork
        begin
          doRead(wa(b + 13, 0), 1'b1, w + 2, "R7 dma first");
          doRead(wa(b + 14, 1), 1'b1, 2 * w + 4, "R7 dma yields slot");
          dReq = 1'b0;
        end
        begin doFetch(wa(b + 15, 0), 2 * w + 4, "R7 instruction takes slot"); iReq = 1'b0; end
      join
      idle(2);
      doRead(wa(b + 16, 0), 1'b1, w + 2, "R7 dma a");
      doRead(wa(b + 17, 0), 1'b1, w + 3, "R7 dma back to back");
      idle(2);
      doRead(wa(b + 16, 1), 1'b0, w + 2, "R7 plain a");
      doRead(wa(b + 17, 1), 1'b0, w + 2, "R7 plain back to back");
      idle(2);

      // abort of prefetch by a jump (R9)
      doFetch(wa(b + 20, 0), w + 2, "R9 setup miss");
      doFetch(wa(b + 20, 1), 1, "R9 setup hit");
      doFetch(wa(b + 30, 0), (w == 0) ? 3 : w + 2, "R9 jump");
      doFetch(wa(b + 21, 0), (w == 0) ? 1 : w + 2, "R9 aborted line");
      idle(2);

      // hit while data read busy (R10)
      fork
        begin doRead(wa(b + 40, 0), 1'b0, w + 2, "R10 data read"); dReq = 1'b0; end
        begin doFetch(wa(b + 30, 1), 1, "R10 hit during data read"); iReq = 1'b0; end
      join
      idle(w + 4);
    end

    // wait-state change during a read (R2)
    waitCfg = 2'd2;
    fork
      begin doRead(wa(300, 0), 1'b0, 4, "R2 latched wait states"); dReq = 1'b0; end
      begin @(negedge clk); waitCfg = 2'd0; end
    join
    idle(1);
    doFetch(wa(301, 0), 2, "R2 new wait states apply");
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule